// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into host memory through a circular ring of receive descriptors. Each descriptor is two 32-bit words. The first is a flags word that carries an ownership bit and a length field. The second is the byte address of the frame buffer. The host arms a descriptor by setting its ownership bit and writing the buffer capacity into the length field. The engine reads the armed descriptor and stores the incoming bytes one at a time into the buffer. After the last byte it writes the flags word back with the ownership bit cleared and the received length. It then raises a receive interrupt and moves on to the next descriptor.

When the engine reaches a descriptor the host has not armed, it stalls. A frame that arrives while it is stalled is consumed and discarded, and the drop is counted. The engine reads the descriptor again after each dropped frame and whenever the wakeup strobe pulses. Writing the ring base register points the engine at a new ring and restarts it at entry 0.

Top module: `rxring_dma`

## Requirements
- R1: After reset, `irq`, `stat_drop` and `stat_small` are 0 and `drop_cnt` is 0.
- R2: The bytes of a received frame are stored in arrival order at consecutive byte addresses, starting at the buffer address held in the descriptor's second word (offset 4).
- R3: On completion, the flags word (offset 0) is rewritten with bit 31 (owner) cleared. Bits [LEN_W-1:0] then hold the total byte count of the frame, and that count includes the trailing 4-byte FCS.
- R4: The flags word is not rewritten while a frame is incomplete. Until the last byte has been stored, the host still sees bit 31 set.
- R5: Descriptors are used in order. Descriptor i sits at ring base + 8*i, and the index wraps from RING_SIZE-1 to 0.
- R6: Each completed frame sets a pending receive interrupt. `irq` is the pending bit gated by `irq_mask`, where 0 means enabled. A masked interrupt stays pending until `int_clr`.
- R7: A frame that arrives while the current descriptor has bit 31 clear is dropped. Nothing is written to memory, `stat_drop` is set and `drop_cnt` goes up by one, saturating at its maximum.
- R8: A stalled engine reads the current descriptor again on a `wake` pulse, and then fills it if the host has armed it.
- R9: Bytes beyond the buffer length taken from the armed flags word are not stored. Such a frame still writes back its full byte count, with bit 30 of the flags word set, and it sets `stat_small`.
- R10: Writing `base_data` with `base_wr` selects a new ring and resets the descriptor index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte (last FCS byte) of a frame |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request, always granted |
| mem_we | output | 1 | 1 = write, 0 = read (data returned next cycle) |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| base_wr | input | 1 | Ring base write strobe |
| base_data | input | ADDR_W | New ring base address |
| wake | input | 1 | Re-read the current descriptor while stalled |
| irq_mask | input | 1 | 1 masks the receive interrupt |
| int_clr | input | 1 | Clears the pending interrupt and the status flags |
| irq | output | 1 | Receive interrupt |
| stat_drop | output | 1 | A frame was dropped |
| stat_small | output | 1 | A frame overflowed its buffer |
| drop_cnt | output | DROP_W | Count of dropped frames, saturating |

## Verification
The frames differ in length and in starting byte value, so a misplaced or reordered byte shows up as a data mismatch. One frame pauses in the middle, which tells an early descriptor write-back apart from a correct one. A run of frames wraps the ring, proving that the index wraps rather than running off the end. Other frames arrive on a descriptor that is not armed, on one armed only after a wake pulse, into a buffer shorter than the frame, and after a base write. Between them these show that dropping, resuming, truncating and re-basing each alter memory and status only as required.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [2:0] {
      S_FETCH, S_FLAGS, S_AREQ, S_ADDR, S_RECV, S_DROP, S_STALL, S_WB
   } rx_state_t;

   localparam int OWN_BIT    = 31;
   localparam int SMALL_BIT  = 30;
   localparam int DESC_BYTES = 8;
   localparam int PTR_OFS    = 4;
endpackage

// File: rtl/rxr_ring_idx.sv
module rxr_ring_idx #(
   parameter int ADDR_W    = 32,
   parameter int RING_SIZE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_data,
   input  logic              adv,
   output logic [ADDR_W-1:0] desc_addr
);
   localparam int IDX_W = $clog2(RING_SIZE);

   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;

   generate
      if (RING_SIZE < 2 || (RING_SIZE & (RING_SIZE - 1)) != 0) begin : g_bad_ring
         $error("RING_SIZE must be a power of two of at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         idx_q  <= '0;
      end else if (base_wr) begin
         base_q <= base_data;
         idx_q  <= '0;
      end else if (adv) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign desc_addr = base_q + (ADDR_W'(idx_q) << $clog2(rxr_pkg::DESC_BYTES));

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q != $past(idx_q)) |-> ($past(base_wr) || idx_q == IDX_W'($past(idx_q) + 1'b1)))
      else $error("index moved other than by one step"); // R5
   AST_BASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      $past(base_wr) |-> (idx_q == '0))
      else $error("index not reset by base write"); // R10
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
   parameter int DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic              small_evt,
   input  logic              drop_evt,
   input  logic              int_clr,
   input  logic              irq_mask,
   output logic              irq,
   output logic              pend,
   output logic              stat_drop,
   output logic              stat_small,
   output logic [DROP_W-1:0] drop_cnt
);
   generate
      if (DROP_W < 1 || DROP_W > 32) begin : g_bad_cnt
         $error("DROP_W must lie in 1..32");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend       <= 1'b0;
         stat_drop  <= 1'b0;
         stat_small <= 1'b0;
         drop_cnt   <= '0;
      end else begin
         if (done)         pend <= 1'b1;
         else if (int_clr) pend <= 1'b0;
         if (drop_evt)     stat_drop <= 1'b1;
         else if (int_clr) stat_drop <= 1'b0;
         if (done && small_evt) stat_small <= 1'b1;
         else if (int_clr)      stat_small <= 1'b0;
         if (drop_evt && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
      end
   end

   assign irq = pend & ~irq_mask;

   AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt != $past(drop_cnt)) |-> $past(drop_evt))
      else $error("drop count moved without a drop"); // R7
   AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(int_clr && !done) |-> !pend)
      else $error("pending interrupt survived a clear"); // R6
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma #(
   parameter int ADDR_W    = 32,
   parameter int RING_SIZE = 16,
   parameter int BUF_BYTES = 1600,
   parameter int DROP_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic              in_last,
   output logic              in_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              base_wr,
   input  logic [ADDR_W-1:0] base_data,
   input  logic              wake,
   input  logic              irq_mask,
   input  logic              int_clr,
   output logic              irq,
   output logic              stat_drop,
   output logic              stat_small,
   output logic [DROP_W-1:0] drop_cnt
);
   import rxr_pkg::*;

   localparam int LEN_W = $clog2(BUF_BYTES + 1);

   generate
      if (LEN_W > SMALL_BIT) begin : g_bad_len
         $error("BUF_BYTES too large for the length field");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
   endgenerate

   rx_state_t         st;
   logic [LEN_W-1:0]  buf_len;
   logic [LEN_W-1:0]  cnt;
   logic [ADDR_W-1:0] buf_addr;
   logic [ADDR_W-1:0] desc_addr;
   logic [ADDR_W-1:0] byte_addr;
   logic              small_q;
   logic              fits;
   logic              accept;
   logic              done;
   logic              drop_evt;
   logic              pend;

   assign in_ready  = (st == S_RECV) || (st == S_STALL) || (st == S_DROP);
   assign accept    = in_valid && in_ready;
   assign fits      = cnt < buf_len;
   assign done      = (st == S_WB);
   assign drop_evt  = accept && in_last && ((st == S_STALL) || (st == S_DROP));
   assign byte_addr = buf_addr + ADDR_W'(cnt);

   rxr_ring_idx #(.ADDR_W(ADDR_W), .RING_SIZE(RING_SIZE)) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_wr   (base_wr),
      .base_data (base_data),
      .adv       (done),
      .desc_addr (desc_addr)
   );

   rxr_status #(.DROP_W(DROP_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .small_evt  (small_q),
      .drop_evt   (drop_evt),
      .int_clr    (int_clr),
      .irq_mask   (irq_mask),
      .irq        (irq),
      .pend       (pend),
      .stat_drop  (stat_drop),
      .stat_small (stat_small),
      .drop_cnt   (drop_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_FETCH;
         buf_len  <= '0;
         buf_addr <= '0;
         cnt      <= '0;
         small_q  <= 1'b0;
      end else if (base_wr) begin
         st      <= S_FETCH;
         cnt     <= '0;
         small_q <= 1'b0;
      end else begin
         case (st)
            S_FETCH: st <= S_FLAGS;
            S_FLAGS: begin
               if (mem_rdata[OWN_BIT]) begin
                  buf_len <= mem_rdata[LEN_W-1:0];
                  st      <= S_AREQ;
               end else begin
                  st <= S_STALL;
               end
            end
            S_AREQ: st <= S_ADDR;
            S_ADDR: begin
               buf_addr <= mem_rdata[ADDR_W-1:0];
               cnt      <= '0;
               small_q  <= 1'b0;
               st       <= S_RECV;
            end
            S_RECV: begin
               if (in_valid) begin
                  cnt <= cnt + 1'b1;
                  if (!fits) small_q <= 1'b1;
                  if (in_last) st <= S_WB;
               end
            end
            S_STALL: begin
               if (in_valid)  st <= in_last ? S_FETCH : S_DROP;
               else if (wake) st <= S_FETCH;
            end
            S_DROP: if (in_valid && in_last) st <= S_FETCH;
            S_WB:   st <= S_FETCH;
            default: st <= S_FETCH;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_addr;
      mem_be    = 4'h0;
      mem_wdata = '0;
      case (st)
         S_FETCH: mem_req = 1'b1;
         S_AREQ: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + ADDR_W'(PTR_OFS);
         end
         S_RECV: begin
            mem_req   = accept && fits;
            mem_we    = 1'b1;
            mem_addr  = byte_addr;
            mem_be    = 4'b0001 << byte_addr[1:0];
            mem_wdata = {4{in_data}};
         end
         S_WB: begin
            mem_req              = 1'b1;
            mem_we               = 1'b1;
            mem_be               = 4'hF;
            mem_wdata[LEN_W-1:0] = cnt;
            mem_wdata[SMALL_BIT] = small_q;
         end
         default: ;
      endcase
   end

   AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st == S_RECV) |-> ($countones(mem_be) == 1))
      else $error("buffer write touches more than one lane"); // R2
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && st == S_RECV) |-> ((mem_addr - buf_addr) < ADDR_W'(buf_len)))
      else $error("write beyond the programmed buffer"); // R9
   AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_WB) |-> $past(in_valid && in_last && st == S_RECV))
      else $error("descriptor written back before the last byte"); // R4
   AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_DROP || st == S_STALL) |-> !mem_req)
      else $error("memory touched while dropping"); // R7
   AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(st == S_WB))
      else $error("interrupt without a completion"); // R6
endmodule

// File: tb/rxring_dma_test.sv
`timescale 1ns/1ps
module rxring_dma_test;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_data = '0;
   logic          in_last = 1'b0;
   logic          in_ready;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [3:0]    mem_be;
   logic [31:0]   mem_wdata;
   logic [31:0]   mem_rdata = '0;
   logic          base_wr = 1'b0;
   logic [AW-1:0] base_data = '0;
   logic          wake = 1'b0;
   logic          irq_mask = 1'b0;
   logic          int_clr = 1'b0;
   logic          irq, stat_drop, stat_small;
   logic [7:0]    drop_cnt;

   logic [7:0] mem [0:4095];
   int n_chk = 0;
   int n_err = 0;
   bit ended = 0;

   always #2.5 clk = ~clk;

   rxring_dma #(.ADDR_W(AW), .RING_SIZE(4), .BUF_BYTES(1600), .DROP_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .base_wr(base_wr), .base_data(base_data),
      .wake(wake), .irq_mask(irq_mask), .int_clr(int_clr), .irq(irq),
      .stat_drop(stat_drop), .stat_small(stat_small), .drop_cnt(drop_cnt)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) mem[{mem_addr[11:2], 2'(b)}] = mem_wdata[8*b +: 8];
         end else begin
            mem_rdata <= {mem[{mem_addr[11:2], 2'd3}], mem[{mem_addr[11:2], 2'd2}],
                          mem[{mem_addr[11:2], 2'd1}], mem[{mem_addr[11:2], 2'd0}]};
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   function automatic logic [31:0] rd32(input int a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic wr32(input int a, input logic [31:0] v);
      for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
   endtask

   task automatic arm(input int base, input int i, input int len, input int baddr);
      wr32(base + 8*i + 4, 32'(baddr));
      wr32(base + 8*i, 32'h8000_0000 | 32'(len));
   endtask

   function automatic logic [7:0] pat(input int seed, input int k);
      return 8'(seed + 3*k);
   endfunction

   task automatic send_byte(input logic [7:0] d, input logic l);
      in_valid = 1'b1; in_data = d; in_last = l;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic send_part(input int seed, input int from, input int n, input bit fin);
      for (int k = from; k < from + n; k++)
         send_byte(pat(seed, k), fin && (k == from + n - 1));
   endtask

   function automatic int mism(input int baddr, input int seed, input int n);
      int m = 0;
      for (int k = 0; k < n; k++) if (mem[baddr+k] !== pat(seed, k)) m++;
      return m;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_int();
      int_clr = 1'b1; @(negedge clk); int_clr = 1'b0; @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 irq", irq, 0);
      chk("R1 stat_drop", stat_drop, 0);
      chk("R1 stat_small", stat_small, 0);
      chk("R1 drop_cnt", drop_cnt, 0);
   endtask

   task automatic t_basic();
      send_part(8'h10, 0, 10, 0);
      idle(3);
      chk("R4 owner kept mid-frame", rd32(0), 32'h8000_0640);
      chk("R6 no irq mid-frame", irq, 0);
      send_part(8'h10, 10, 10, 1);
      idle(4);
      chk("R3 flags word", rd32(0), 32'd20);
      chk("R2 buffer data", mism(32'h100, 8'h10, 20), 0);
      chk("R6 irq raised", irq, 1);
      clear_int();
      chk("R6 irq cleared", irq, 0);
   endtask

   task automatic t_mask();
      irq_mask = 1'b1;
      send_part(8'h40, 0, 64, 1);
      idle(4);
      chk("R6 masked irq", irq, 0);
      chk("R3 flags desc1", rd32(8), 32'd64);
      chk("R2 data desc1", mism(32'h200, 8'h40, 64), 0);
      irq_mask = 1'b0;
      idle(1);
      chk("R6 pending kept under mask", irq, 1);
      clear_int();
   endtask

   task automatic t_wrap();
      send_part(8'h70, 0, 33, 1);
      idle(4);
      chk("R5 desc2 flags", rd32(16), 32'd33);
      arm(0, 0, 1600, 32'h100);
      send_part(8'h90, 0, 40, 1);
      idle(4);
      chk("R5 desc3 flags", rd32(24), 32'd40);
      send_part(8'hA0, 0, 28, 1);
      idle(4);
      chk("R5 wrapped to desc0", rd32(0), 32'd28);
      chk("R5 wrapped data", mism(32'h100, 8'hA0, 28), 0);
      clear_int();
   endtask

   task automatic t_drop();
      send_part(8'hC0, 0, 30, 1);
      idle(4);
      chk("R7 drop count", drop_cnt, 1);
      chk("R7 drop status", stat_drop, 1);
      chk("R7 no irq on drop", irq, 0);
      chk("R7 desc1 untouched", rd32(8), 32'd64);
      chk("R7 buffer untouched", mism(32'h200, 8'h40, 64), 0);
      clear_int();
      chk("R7 drop status cleared", stat_drop, 0);
   endtask

   task automatic t_wake();
      arm(0, 1, 1600, 32'h200);
      wake = 1'b1; @(negedge clk); wake = 1'b0;
      send_part(8'hD0, 0, 25, 1);
      idle(4);
      chk("R8 desc1 after wake", rd32(8), 32'd25);
      chk("R8 data after wake", mism(32'h200, 8'hD0, 25), 0);
      chk("R8 no further drop", drop_cnt, 1);
      clear_int();
   endtask

   task automatic t_small();
      for (int k = 0; k < 32; k++) mem[32'h300 + k] = 8'hEE;
      arm(0, 2, 16, 32'h300);
      wake = 1'b1; @(negedge clk); wake = 1'b0;
      send_part(8'hE0, 0, 24, 1);
      idle(4);
      chk("R9 flags with overflow bit", rd32(16), 32'h4000_0018);
      chk("R9 stored part", mism(32'h300, 8'hE0, 16), 0);
      chk("R9 byte past buffer", mem[32'h310], 8'hEE);
      chk("R9 stat_small", stat_small, 1);
      chk("R9 irq", irq, 1);
      clear_int();
      chk("R9 stat_small cleared", stat_small, 0);
   endtask

   task automatic t_base();
      arm(32'h800, 0, 1600, 32'h900);
      base_data = 16'h0800; base_wr = 1'b1; @(negedge clk); base_wr = 1'b0;
      send_part(8'h33, 0, 22, 1);
      idle(4);
      chk("R10 new ring desc0", rd32(32'h800), 32'd22);
      chk("R10 new ring data", mism(32'h900, 8'h33, 22), 0);
      chk("R10 old ring untouched", rd32(24), 32'd40);
      chk("R10 irq", irq, 1);
   endtask

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
      for (int i = 0; i < 4; i++) arm(0, i, 1600, 32'h100 * (i + 1));
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      t_basic();
      t_mask();
      t_wrap();
      t_drop();
      t_wake();
      t_small();
      t_base();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule